// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from memory to a byte stream. Software builds a circular list of 8-byte transmit descriptors in memory and tells the engine where the list begins. A pulse on `kick` while `enable` is high sets the engine walking. For each descriptor that software has marked ready, it fetches the buffer pointer, reads the buffer byte by byte through a single-outstanding memory port, and emits the bytes on `tx_data`. It then hands the descriptor back by writing it with the ready flag cleared. A frame may span several descriptors. The descriptor that carries the last flag closes the frame, and the final byte of the frame is marked with `tx_last`.

Descriptor layout, little-endian words: word 0 holds the buffer length in bits 15:0 and the flags in bits 31:16. Word 1 holds the buffer byte address. Within the 16-bit flags, ready is bit 15, wrap is bit 13 and last is bit 11. A frame never exceeds `MAX_FRAME` bytes (2047 by default). Excess bytes are neither read nor sent, and a babble event is raised. Three one-cycle event pulses (buffer done, frame done, babble) feed an interrupt event register outside the block.

Top module: `txr_engine`

## Requirements
- R1: A walk starts only on a `kick` pulse while `enable` is 1. A `kick` with `enable` at 0 starts no memory request.
- R2: The engine reads word 0 at the current descriptor address. If flag bit 15 (word bit 31) is 0, it stops, and the next walk re-reads that same address.
- R3: Buffer bytes are sent in ascending address order from the buffer address, which may be unaligned. The byte at address A is lane A[1:0] of the 32-bit word at A with its low two bits cleared, with lane 0 in bits 7:0.
- R4: `tx_last` marks only the final byte of a frame. A frame closes on a descriptor with flag bit 11 set, and descriptors without it extend the same frame.
- R5: When bytes already gathered plus the descriptor length exceed `MAX_FRAME`, only `MAX_FRAME` minus gathered bytes are read and sent, and `ev_babble` pulses once.
- R6: After its bytes, each descriptor's word 0 is written back with bit 31 cleared and the length field unchanged. `ev_txb` then pulses once.
- R7: A descriptor with the last flag pulses `ev_txf` together with its `ev_txb` and resets the gathered byte count to 0 for the next frame.
- R8: After a descriptor with flag bit 13 set, the next descriptor address is the ring start. Otherwise it is the current address plus 8.
- R9: A write of the ring start clears the low two address bits and also sets the current descriptor address to that value.
- R10: A `kick` (with `enable`) that arrives during a walk causes one extra read of word 0 at the stop address once the walk ends.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` accepts the request. A read's data is taken on the first `mem_rvalid` after acceptance.
- R12: Under reset, `mem_req`, `tx_valid` and all event pulses are 0, and the current descriptor address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable level |
| kick | input | 1 | One-cycle transmit activate pulse |
| base_wr | input | 1 | Ring start write strobe |
| base_data | input | AW | Ring start address to write |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| ev_txb | output | 1 | Buffer handed back pulse |
| ev_txf | output | 1 | Frame complete pulse |
| ev_babble | output | 1 | Frame clipped pulse |

## Verification
Two situations are hard to reach from the ports: clipping and a kick that lands mid-walk. To reach the clip, the bench builds a frame from a 2000-byte buffer followed by a 100-byte buffer. It then checks that only 47 bytes of the second buffer are fetched and that the written-back length still reads 100. For the mid-walk kick, the bench pulses `kick` a few cycles into a walk whose second descriptor is not ready. It then counts the reads of that descriptor in its memory model. A stalling `mem_ready` pattern in one scenario exercises the request-hold rule.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_D0,
        ST_D0W,
        ST_D1,
        ST_D1W,
        ST_DR,
        ST_DW,
        ST_WB
    } st_e;
endpackage

// File: rtl/txr_clip.sv
module txr_clip #(
    parameter int MAX_FRAME = 2047,
    parameter int CNT_W     = 11
) (
    input  logic [CNT_W-1:0] gathered,
    input  logic [15:0]      req_len,
    output logic [15:0]      take_len,
    output logic             over
);
    localparam int SUM_W = ((CNT_W > 16) ? CNT_W : 16) + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] room;

    always_comb begin
        sum      = SUM_W'(gathered) + SUM_W'(req_len);
        room     = SUM_W'(MAX_FRAME) - SUM_W'(gathered);
        over     = sum > SUM_W'(MAX_FRAME);
        take_len = over ? 16'(room) : req_len;
    end
endmodule

// File: rtl/txr_hold.sv
module txr_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       flush,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last
);
    typedef struct packed {
        logic       hv;
        logic [7:0] hb;
        logic       ov;
        logic [7:0] ob;
        logic       ol;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d    = hold_q;
        hold_d.ov = 1'b0;
        hold_d.ol = 1'b0;
        if (flush) begin
            if (hold_q.hv) begin
                hold_d.ov = 1'b1;
                hold_d.ob = hold_q.hb;
                hold_d.ol = 1'b1;
            end
            hold_d.hv = 1'b0;
        end else if (push) begin
            if (hold_q.hv) begin
                hold_d.ov = 1'b1;
                hold_d.ob = hold_q.hb;
            end
            hold_d.hb = push_byte;
            hold_d.hv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign tx_valid = hold_q.ov;
    assign tx_data  = hold_q.ob;
    assign tx_last  = hold_q.ol;

    a_r4_push_flush_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && flush));
    a_r4_flush_emits_last: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && hold_q.hv) |=> (tx_valid && tx_last));
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2047
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          kick,
    input  logic          base_wr,
    input  logic [AW-1:0] base_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          ev_txb,
    output logic          ev_txf,
    output logic          ev_babble
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam logic [AW-1:0] ALIGN = ~AW'(3);

    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    base;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    baddr;
        logic [AW-1:0]    addr;
        logic [31:0]      wdata;
        logic [15:0]      flags;
        logic [15:0]      len;
        logic [15:0]      remain;
        logic [CNT_W-1:0] fcnt;
        logic             pend;
        logic             req;
        logic             we;
        logic             ev_b;
        logic             ev_f;
        logic             ev_bab;
    } eng_t;

    eng_t eng_d, eng_q;

    logic          push;
    logic          flush;
    logic [7:0]    push_byte;
    logic [15:0]   take_len;
    logic          over;
    logic [AW-1:0] next_ptr;
    logic [AW-1:0] next_baddr;

    txr_clip #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_clip (
        .gathered (eng_q.fcnt),
        .req_len  (eng_q.len),
        .take_len (take_len),
        .over     (over)
    );

    txr_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (push_byte),
        .flush     (flush),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last)
    );

    always_comb begin
        eng_d        = eng_q;
        eng_d.ev_b   = 1'b0;
        eng_d.ev_f   = 1'b0;
        eng_d.ev_bab = 1'b0;
        push         = 1'b0;
        flush        = 1'b0;
        push_byte    = 8'(mem_rdata >> {eng_q.baddr[1:0], 3'b000});
        next_ptr     = eng_q.flags[FLAG_WRAP] ? eng_q.base : eng_q.cur + AW'(8);
        next_baddr   = eng_q.baddr + AW'(1);

        if (base_wr) begin
            eng_d.base = base_data & ALIGN;
            eng_d.cur  = base_data & ALIGN;
        end
        if (kick && enable && eng_q.st != ST_IDLE) eng_d.pend = 1'b1;

        case (eng_q.st)
            ST_IDLE: begin
                if (kick && enable) begin
                    eng_d.st   = ST_D0;
                    eng_d.req  = 1'b1;
                    eng_d.we   = 1'b0;
                    eng_d.addr = eng_d.cur;
                end
            end
            ST_D0, ST_D1, ST_DR: begin
                if (mem_ready) begin
                    eng_d.req = 1'b0;
                    eng_d.st  = (eng_q.st == ST_D0) ? ST_D0W :
                                (eng_q.st == ST_D1) ? ST_D1W : ST_DW;
                end
            end
            ST_D0W: begin
                if (mem_rvalid) begin
                    eng_d.len   = mem_rdata[15:0];
                    eng_d.flags = mem_rdata[31:16];
                    if (mem_rdata[16 + FLAG_READY]) begin
                        eng_d.st   = ST_D1;
                        eng_d.req  = 1'b1;
                        eng_d.addr = eng_q.cur + AW'(4);
                    end else if (eng_q.pend) begin
                        eng_d.pend = 1'b0;
                        eng_d.st   = ST_D0;
                        eng_d.req  = 1'b1;
                        eng_d.addr = eng_q.cur;
                    end else begin
                        eng_d.st = ST_IDLE;
                    end
                end
            end
            ST_D1W: begin
                if (mem_rvalid) begin
                    eng_d.baddr  = AW'(mem_rdata);
                    eng_d.remain = take_len;
                    eng_d.ev_bab = over;
                    eng_d.fcnt   = eng_q.fcnt + CNT_W'(take_len);
                    eng_d.req    = 1'b1;
                    if (take_len == '0) begin
                        eng_d.st    = ST_WB;
                        eng_d.we    = 1'b1;
                        eng_d.addr  = eng_q.cur;
                        eng_d.wdata = {eng_q.flags & ~(16'(1) << FLAG_READY), eng_q.len};
                    end else begin
                        eng_d.st   = ST_DR;
                        eng_d.addr = AW'(mem_rdata) & ALIGN;
                    end
                end
            end
            ST_DW: begin
                if (mem_rvalid) begin
                    push         = 1'b1;
                    eng_d.baddr  = next_baddr;
                    eng_d.remain = eng_q.remain - 16'd1;
                    eng_d.req    = 1'b1;
                    if (eng_q.remain == 16'd1) begin
                        eng_d.st    = ST_WB;
                        eng_d.we    = 1'b1;
                        eng_d.addr  = eng_q.cur;
                        eng_d.wdata = {eng_q.flags & ~(16'(1) << FLAG_READY), eng_q.len};
                    end else begin
                        eng_d.st   = ST_DR;
                        eng_d.addr = next_baddr & ALIGN;
                    end
                end
            end
            ST_WB: begin
                if (mem_ready) begin
                    eng_d.ev_b = 1'b1;
                    if (eng_q.flags[FLAG_LAST]) begin
                        flush      = 1'b1;
                        eng_d.ev_f = 1'b1;
                        eng_d.fcnt = '0;
                    end
                    eng_d.cur  = next_ptr;
                    eng_d.st   = ST_D0;
                    eng_d.req  = 1'b1;
                    eng_d.we   = 1'b0;
                    eng_d.addr = next_ptr;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mem_req   = eng_q.req;
    assign mem_we    = eng_q.we;
    assign mem_addr  = eng_q.addr;
    assign mem_wdata = eng_q.wdata;
    assign ev_txb    = eng_q.ev_b;
    assign ev_txf    = eng_q.ev_f;
    assign ev_babble = eng_q.ev_bab;

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));
    a_r1_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_IDLE && !(kick && enable)) |=> !mem_req);
    a_r6_txb_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txb |-> $past(mem_req && mem_we && mem_ready));
    a_r7_frame_has_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txf |-> ev_txb);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.fcnt <= CNT_W'(MAX_FRAME));
    a_r5_full_on_babble: assert property (@(posedge clk) disable iff (!rst_n)
        ev_babble |-> (eng_q.fcnt == CNT_W'(MAX_FRAME)));
    a_r2_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_q.st) == ST_D0W && eng_q.st == ST_IDLE && !$past(base_wr))
            |-> $stable(eng_q.cur));
endmodule

// File: tb/tb_txr_engine.sv
`timescale 1ns/1ps
module tb_txr_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        kick = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        ev_txb, ev_txf, ev_babble;

    always #4 clk = ~clk;

    txr_engine dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
        .base_wr(base_wr), .base_data(base_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babble(ev_babble)
    );

    logic [31:0] mem [0:4095];
    logic [31:0] rd_log [0:8191];
    logic [31:0] wr_addr [0:63];
    logic [31:0] wr_data [0:63];
    logic [7:0]  cap_b [0:4095];
    logic        cap_l [0:4095];
    int rd_n = 0, wr_n = 0, cap_n = 0, n_txb = 0, n_txf = 0, n_bab = 0;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit stall = 1'b0;
    bit rd_pend = 1'b0;
    logic [31:0] rd_a = '0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7) + (a >> 8) + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory model and output monitor, both on the falling edge
    initial begin
        for (int i = 0; i < 4096; i++)
            mem[i] = {pat(i*4+3), pat(i*4+2), pat(i*4+1), pat(i*4)};
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = rd_pend;
            if (rd_pend) mem_rdata = mem[rd_a[13:2]];
            rd_pend = 1'b0;
            mem_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (rst_n && mem_req && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    if (wr_n < 64) begin
                        wr_addr[wr_n] = mem_addr;
                        wr_data[wr_n] = mem_wdata;
                    end
                    wr_n++;
                end else begin
                    rd_pend = 1'b1;
                    rd_a = mem_addr;
                    if (rd_n < 8192) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end
            if (tx_valid && cap_n < 4096) begin
                cap_b[cap_n] = tx_data;
                cap_l[cap_n] = tx_last;
                cap_n++;
            end
            if (ev_txb) n_txb++;
            if (ev_txf) n_txf++;
            if (ev_babble) n_bab++;
        end
    end

    task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] b);
        mem[a >> 2]       = {fl, ln};
        mem[(a >> 2) + 1] = b;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_wr = 1'b1; base_data = v;
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 40) begin
            @(negedge clk);
            if (mem_req) q = 0; else q++;
        end
    endtask

    function automatic int count_reads(input int from, input int lo, input int hi);
        int c = 0;
        for (int i = from; i < rd_n; i++)
            if (rd_log[i] >= lo && rd_log[i] < hi) c++;
        return c;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(!mem_req && !tx_valid && !ev_txb && !ev_txf && !ev_babble, "R12 reset quiet",
            {mem_req, tx_valid, ev_txb, ev_txf, ev_babble}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_no_enable();
        int r0 = rd_n;
        enable = 1'b0;
        pulse_kick();
        repeat (20) @(negedge clk);
        chk(rd_n == r0 && !mem_req, "R1 kick without enable", rd_n - r0, 0);
        enable = 1'b1;
        mem[0] = '0;
        r0 = rd_n;
        pulse_kick();
        wait_idle();
        chk(rd_n - r0 == 1 && rd_log[r0] == 0, "R12 pointer starts at zero", rd_log[r0], 0);
    endtask

    task automatic t_single();
        int c0 = cap_n, b0 = txb_snap(), w0 = wr_n, r0;
        int f0 = n_txf;
        put_desc(32'h100, 16'h8800, 16'd5, 32'h1003);
        mem[32'h108 >> 2] = '0;
        set_base(32'h103);
        pulse_kick();
        wait_idle();
        chk(cap_n - c0 == 5, "R3 byte count", cap_n - c0, 5);
        for (int j = 0; j < 5; j++) begin
            chk(cap_b[c0+j] == pat(32'h1003 + j), "R3 unaligned byte order", cap_b[c0+j], pat(32'h1003 + j));
            chk(cap_l[c0+j] == (j == 4), "R4 last marker", cap_l[c0+j], j == 4);
        end
        chk(n_txb - b0 == 1 && n_txf - f0 == 1, "R7 frame and buffer events", n_txf - f0, 1);
        chk(wr_n - w0 == 1 && wr_addr[w0] == 32'h100 && wr_data[w0] == 32'h0800_0005,
            "R6 writeback clears ready", wr_data[w0], 32'h0800_0005);
        r0 = rd_n;
        pulse_kick();
        wait_idle();
        chk(rd_log[r0] == 32'h108, "R2 stop keeps pointer / R9 aligned base", rd_log[r0], 32'h108);
    endtask

    function automatic int txb_snap();
        return n_txb;
    endfunction

    task automatic t_multi();
        int c0 = cap_n, b0 = n_txb, f0 = n_txf, w0 = wr_n, r0 = rd_n;
        put_desc(32'h200, 16'h8000, 16'd3, 32'h1100);
        put_desc(32'h208, 16'h8800, 16'd2, 32'h1201);
        put_desc(32'h210, 16'hA800, 16'd4, 32'h1302);
        stall = 1'b1;
        set_base(32'h200);
        pulse_kick();
        wait_idle();
        stall = 1'b0;
        chk(cap_n - c0 == 9, "R4 multi-buffer byte count", cap_n - c0, 9);
        for (int j = 0; j < 9; j++) begin
            logic [7:0] e;
            e = (j < 3) ? pat(32'h1100 + j) : (j < 5) ? pat(32'h1201 + j - 3) : pat(32'h1302 + j - 5);
            chk(cap_b[c0+j] == e, "R3 stream bytes under stalls (R11)", cap_b[c0+j], e);
            chk(cap_l[c0+j] == (j == 4 || j == 8), "R4 frame boundaries", cap_l[c0+j], j == 4 || j == 8);
        end
        chk(n_txb - b0 == 3 && n_txf - f0 == 2, "R6 R7 event counts", (n_txb - b0) * 16 + n_txf - f0, 32'h32);
        chk(wr_n - w0 == 3 && wr_data[w0] == 32'h0000_0003 && wr_data[w0+1] == 32'h0800_0002
            && wr_data[w0+2] == 32'h2800_0004, "R6 writebacks", wr_data[w0+2], 32'h2800_0004);
        chk(count_reads(r0, 32'h200, 32'h218) == 7, "R8 ring reads", count_reads(r0, 32'h200, 32'h218), 7);
        begin
            int k = 0;
            logic [31:0] seventh = '0;
            for (int i = r0; i < rd_n; i++)
                if (rd_log[i] >= 32'h200 && rd_log[i] < 32'h218) begin
                    k++;
                    if (k == 7) seventh = rd_log[i];
                end
            chk(seventh == 32'h200, "R8 wrap reloads ring start", seventh, 32'h200);
        end
    endtask

    task automatic t_babble();
        int c0 = cap_n, a0 = n_bab, w0 = wr_n, r0 = rd_n;
        put_desc(32'h400, 16'h8000, 16'd2000, 32'h1800);
        put_desc(32'h408, 16'h8800, 16'd100, 32'h2000);
        put_desc(32'h410, 16'hA800, 16'd3, 32'h2100);
        set_base(32'h400);
        pulse_kick();
        wait_idle();
        chk(cap_n - c0 == 2050, "R5 clipped byte total", cap_n - c0, 2050);
        chk(cap_l[c0+2046] == 1'b1 && cap_l[c0+2049] == 1'b1, "R4 last after clip",
            {cap_l[c0+2046], cap_l[c0+2049]}, 3);
        chk(cap_b[c0+2046] == pat(32'h2000 + 46), "R5 final kept byte", cap_b[c0+2046], pat(32'h2000 + 46));
        chk(n_bab - a0 == 1, "R5 single babble event", n_bab - a0, 1);
        chk(count_reads(r0, 32'h2030, 32'h2064) == 0, "R5 excess bytes not read",
            count_reads(r0, 32'h2030, 32'h2064), 0);
        chk(wr_data[w0+1] == 32'h0800_0064, "R6 length unchanged on writeback", wr_data[w0+1], 32'h0800_0064);
        chk(cap_b[c0+2047] == pat(32'h2100) && cap_l[c0+2048] == 1'b0, "R7 count reset next frame",
            cap_b[c0+2047], pat(32'h2100));
    endtask

    task automatic t_pend();
        int r0 = rd_n;
        put_desc(32'h600, 16'h8800, 16'd4, 32'h1400);
        mem[32'h608 >> 2] = '0;
        set_base(32'h600);
        pulse_kick();
        repeat (3) @(negedge clk);
        pulse_kick();
        wait_idle();
        chk(count_reads(r0, 32'h608, 32'h60C) == 2, "R10 kick during walk re-reads",
            count_reads(r0, 32'h608, 32'h60C), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_no_enable();
        t_single();
        t_multi();
        t_babble();
        t_pend();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule